// File: doc/BRIEF.md
# 72-bit SEC-DED Codec with Fixed Column Codes

This block protects a 64-bit memory word with 8 check bits. It uses a fixed, odd-weight parity-check matrix. Each of the 72 stored bits has its own 8-bit column code: 64 data columns and 8 one-hot check columns. The codec has two paths that work independently of each other.

On the write path, the codec forms the check byte from the data word. The memory stores this byte next to the data.

On the read path, the codec recomputes the check byte from the returned data and XORs it with the stored check byte. The result is the syndrome, and the codec compares it against every column code at the same time:
- **Data column match:** the matching data bit is flipped back.
- **Check column match:** the data passes through unchanged and the event is reported as corrected.
- **Nonzero syndrome with no match:** the event is flagged as uncorrectable and the data is returned untouched.

The syndrome and the index of the bit at fault are exported so that software or a logging block can record the event. A parameter selects whether the read result is registered or combinational.

Top module: `ecc72_codec`

## Requirements
- R1: Check byte bit j on `wr_chk` (weight 2^j) equals the XOR of every data bit i whose column code has bit j set. The column codes for data bits 0 to 63 are, in index order: F4 F1 EC EA E9 E6 E5 E3 DC DA D9 D6 D5 D3 CE CB B5 B0 AD AB A8 A7 A4 A2 9D 9B 98 97 94 92 8F 8A 75 70 6D 6B 68 67 64 62 5E 5B 58 57 54 52 4F 4A 34 31 2C 2A 29 26 25 23 1C 1A 19 16 15 13 0E 0B (hex).
- R2: `out_syndrome` equals the check byte recomputed from `rd_data`, XORed with `rd_chk`.
- R3: A zero syndrome returns `rd_data` unchanged, with both flags low and `out_idx` = 0.
- R4: A syndrome equal to the code of data bit i returns `rd_data` with bit i inverted, raises `out_corr`, and sets `out_idx` = i.
- R5: A syndrome equal to 2^j (a single stored check bit in error, stored-bit index 71-j) returns `rd_data` unchanged, raises `out_corr`, and sets `out_idx` = 71-j.
- R6: Any two flipped data bits give an even-weight syndrome. This returns `rd_data` unchanged, raises `out_uncorr`, keeps `out_corr` low, and sets `out_idx` = 0.
- R7: Any other nonzero syndrome that matches no column is also reported as uncorrectable, with the data passed through. This includes two flipped check bits.
- R8: With `OUT_REG` = 1, results appear on the clock edge after `rd_valid` is sampled, and `out_valid` then mirrors the sampled `rd_valid`. When `out_valid` is low, every result output is zero, and reset sets all outputs to zero.
- R9: `out_corr` and `out_uncorr` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_data | input | 64 | Data word being written |
| wr_chk | output | 8 | Check byte for `wr_data` (combinational) |
| rd_valid | input | 1 | Read word present on `rd_data`/`rd_chk` |
| rd_data | input | 64 | Data word as read from memory |
| rd_chk | input | 8 | Check byte as read from memory |
| out_valid | output | 1 | Result outputs hold a decoded read |
| out_data | output | 64 | Corrected or passed-through data |
| out_syndrome | output | 8 | Syndrome of the read |
| out_corr | output | 1 | Single-bit error corrected (data or check bit) |
| out_uncorr | output | 1 | Uncorrectable error detected |
| out_idx | output | 7 | Stored-bit index (0..71) of the corrected bit |

## Verification
A wrong column code or a wrong check mask shows up at once. It gives a wrong `wr_chk` for the same write, and a misplaced flip or a missing `out_corr` on the next registered read result. A fault in the match logic or the index encoder shows in `out_data` or `out_idx` one clock after the offending read. So every single-bit position is driven in turn, for both data and check bits, and each result is compared in the cycle it appears. Double errors and check-only double errors confirm that no even-weight syndrome is mistaken for a correctable one.

// File: rtl/ecc72_pkg.sv
package ecc72_pkg;

    localparam int DATA_W = 64;
    localparam int CHK_W  = 8;
    localparam int CW_W   = DATA_W + CHK_W;
    localparam int IDX_W  = $clog2(CW_W);

    typedef logic [CHK_W-1:0] syn_t;

    // Column code of each data bit, index 0 first.
    localparam syn_t COL_CODE [DATA_W] = '{
        8'hF4, 8'hF1, 8'hEC, 8'hEA, 8'hE9, 8'hE6, 8'hE5, 8'hE3,
        8'hDC, 8'hDA, 8'hD9, 8'hD6, 8'hD5, 8'hD3, 8'hCE, 8'hCB,
        8'hB5, 8'hB0, 8'hAD, 8'hAB, 8'hA8, 8'hA7, 8'hA4, 8'hA2,
        8'h9D, 8'h9B, 8'h98, 8'h97, 8'h94, 8'h92, 8'h8F, 8'h8A,
        8'h75, 8'h70, 8'h6D, 8'h6B, 8'h68, 8'h67, 8'h64, 8'h62,
        8'h5E, 8'h5B, 8'h58, 8'h57, 8'h54, 8'h52, 8'h4F, 8'h4A,
        8'h34, 8'h31, 8'h2C, 8'h2A, 8'h29, 8'h26, 8'h25, 8'h23,
        8'h1C, 8'h1A, 8'h19, 8'h16, 8'h15, 8'h13, 8'h0E, 8'h0B
    };

    // Data bits that feed check byte bit j.
    function automatic logic [DATA_W-1:0] chk_mask(input int j);
        logic [DATA_W-1:0] m;
        for (int i = 0; i < DATA_W; i++) begin
            m[i] = COL_CODE[i][j];
        end
        return m;
    endfunction

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
        syn_t              syn;
        logic              corr;
        logic              uncorr;
        logic [IDX_W-1:0]  idx;
    } dec_res_t;

endpackage

// File: rtl/ecc72_encoder.sv
module ecc72_encoder
    import ecc72_pkg::*;
(
    input  logic [DATA_W-1:0] data,
    output syn_t              chk
);
    for (genvar j = 0; j < CHK_W; j++) begin : g_chk
        localparam logic [DATA_W-1:0] MASK = chk_mask(j);
        assign chk[j] = ^(data & MASK);
    end
endmodule

// File: rtl/ecc72_syndrome.sv
module ecc72_syndrome
    import ecc72_pkg::*;
(
    input  logic [DATA_W-1:0] data,
    input  syn_t              chk,
    output syn_t              syn
);
    syn_t recomputed;

    ecc72_encoder u_enc (
        .data (data),
        .chk  (recomputed)
    );

    assign syn = recomputed ^ chk;
endmodule

// File: rtl/ecc72_corrector.sv
module ecc72_corrector
    import ecc72_pkg::*;
(
    input  syn_t              syn,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out,
    output logic              corr,
    output logic              uncorr,
    output logic [IDX_W-1:0]  idx
);
    logic [DATA_W-1:0] hit_data;
    logic [CHK_W-1:0]  hit_chk;
    logic              any_hit;

    for (genvar i = 0; i < DATA_W; i++) begin : g_dcol
        assign hit_data[i] = (syn == COL_CODE[i]);
    end

    for (genvar j = 0; j < CHK_W; j++) begin : g_ccol
        localparam syn_t ONE_HOT = syn_t'(1) << j;
        assign hit_chk[j] = (syn == ONE_HOT);
    end

    always_comb begin
        any_hit  = (|hit_data) | (|hit_chk);
        data_out = data_in ^ hit_data;
        corr     = any_hit;
        uncorr   = (syn != '0) && !any_hit;
        idx      = '0;
        for (int i = 0; i < DATA_W; i++) begin
            if (hit_data[i]) begin
                idx = IDX_W'(i);
            end
        end
        for (int j = 0; j < CHK_W; j++) begin
            if (hit_chk[j]) begin
                idx = IDX_W'(CW_W - 1 - j);
            end
        end
    end
endmodule

// File: rtl/ecc72_codec.sv
module ecc72_codec
    import ecc72_pkg::*;
#(
    parameter int OUT_REG = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CHK_W-1:0]  wr_chk,
    input  logic              rd_valid,
    input  logic [DATA_W-1:0] rd_data,
    input  logic [CHK_W-1:0]  rd_chk,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic [CHK_W-1:0]  out_syndrome,
    output logic              out_corr,
    output logic              out_uncorr,
    output logic [IDX_W-1:0]  out_idx
);
    syn_t              syn;
    logic [DATA_W-1:0] fixed;
    logic              corr;
    logic              uncorr;
    logic [IDX_W-1:0]  idx;
    dec_res_t          res_d;
    dec_res_t          res_q;

    ecc72_encoder u_wr_enc (
        .data (wr_data),
        .chk  (wr_chk)
    );

    ecc72_syndrome u_syn (
        .data (rd_data),
        .chk  (rd_chk),
        .syn  (syn)
    );

    ecc72_corrector u_fix (
        .syn      (syn),
        .data_in  (rd_data),
        .data_out (fixed),
        .corr     (corr),
        .uncorr   (uncorr),
        .idx      (idx)
    );

    always_comb begin
        res_d = '0;
        if (rd_valid) begin
            res_d.valid  = 1'b1;
            res_d.data   = fixed;
            res_d.syn    = syn;
            res_d.corr   = corr;
            res_d.uncorr = uncorr;
            res_d.idx    = idx;
        end
    end

    if (OUT_REG != 0) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                res_q <= '0;
            end else begin
                res_q <= res_d;
            end
        end
    end else begin : g_comb
        always_comb res_q = res_d;
    end

    assign out_valid    = res_q.valid;
    assign out_data     = res_q.data;
    assign out_syndrome = res_q.syn;
    assign out_corr     = res_q.corr;
    assign out_uncorr   = res_q.uncorr;
    assign out_idx      = res_q.idx;
endmodule

// File: rtl/ecc72_codec_chk.sv
module ecc72_codec_chk
    import ecc72_pkg::*;
#(
    parameter int OUT_REG = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data,
    input logic [CHK_W-1:0]  out_syndrome,
    input logic              out_corr,
    input logic              out_uncorr,
    input logic [IDX_W-1:0]  out_idx
);
    logic [DATA_W-1:0] snap_q;
    logic [DATA_W-1:0] ref_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_q <= '0;
        end else if (rd_valid) begin
            snap_q <= rd_data;
        end
    end

    assign ref_data = (OUT_REG != 0) ? snap_q : rd_data;

    p_clean_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_syndrome == '0) |->
            (!out_corr && !out_uncorr && out_data == ref_data));

    p_one_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_corr && out_idx < IDX_W'(DATA_W)) |->
            ($countones(out_data ^ ref_data) == 1 &&
             out_data[out_idx[5:0]] != ref_data[out_idx[5:0]]));

    p_chk_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_corr && out_idx >= IDX_W'(DATA_W)) |->
            ($countones(out_syndrome) == 1 && out_data == ref_data));

    p_uncorr_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_uncorr) |->
            (out_data == ref_data && out_syndrome != '0));

    p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |->
            (out_data == '0 && out_syndrome == '0 && !out_corr &&
             !out_uncorr && out_idx == '0));

    p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (OUT_REG != 0 && rd_valid) |=> out_valid);

    p_flags_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_corr && out_uncorr));
endmodule

bind ecc72_codec ecc72_codec_chk #(.OUT_REG(OUT_REG)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_valid     (rd_valid),
    .rd_data      (rd_data),
    .out_valid    (out_valid),
    .out_data     (out_data),
    .out_syndrome (out_syndrome),
    .out_corr     (out_corr),
    .out_uncorr   (out_uncorr),
    .out_idx      (out_idx)
);

// File: tb/sim_ecc72_codec.sv
module sim_ecc72_codec;
    localparam int CLK_PERIOD = 10;

    localparam bit [7:0] CODES [64] = '{
        8'hF4, 8'hF1, 8'hEC, 8'hEA, 8'hE9, 8'hE6, 8'hE5, 8'hE3,
        8'hDC, 8'hDA, 8'hD9, 8'hD6, 8'hD5, 8'hD3, 8'hCE, 8'hCB,
        8'hB5, 8'hB0, 8'hAD, 8'hAB, 8'hA8, 8'hA7, 8'hA4, 8'hA2,
        8'h9D, 8'h9B, 8'h98, 8'h97, 8'h94, 8'h92, 8'h8F, 8'h8A,
        8'h75, 8'h70, 8'h6D, 8'h6B, 8'h68, 8'h67, 8'h64, 8'h62,
        8'h5E, 8'h5B, 8'h58, 8'h57, 8'h54, 8'h52, 8'h4F, 8'h4A,
        8'h34, 8'h31, 8'h2C, 8'h2A, 8'h29, 8'h26, 8'h25, 8'h23,
        8'h1C, 8'h1A, 8'h19, 8'h16, 8'h15, 8'h13, 8'h0E, 8'h0B
    };

    typedef struct {
        bit        valid;
        bit [63:0] data;
        bit [7:0]  syn;
        bit        corr;
        bit        uncorr;
        bit [6:0]  idx;
        string     tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [63:0] wr_data;
    logic [7:0]  wr_chk;
    logic        rd_valid;
    logic [63:0] rd_data;
    logic [7:0]  rd_chk;
    logic        out_valid;
    logic [63:0] out_data;
    logic [7:0]  out_syndrome;
    logic        out_corr;
    logic        out_uncorr;
    logic [6:0]  out_idx;

    int   n_total = 0;
    int   n_bad   = 0;
    bit   ended   = 1'b0;
    exp_t pend[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ecc72_codec #(.OUT_REG(1)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_data      (wr_data),
        .wr_chk       (wr_chk),
        .rd_valid     (rd_valid),
        .rd_data      (rd_data),
        .rd_chk       (rd_chk),
        .out_valid    (out_valid),
        .out_data     (out_data),
        .out_syndrome (out_syndrome),
        .out_corr     (out_corr),
        .out_uncorr   (out_uncorr),
        .out_idx      (out_idx)
    );

    function automatic bit [7:0] ref_code(int i);
        if (i < 64) return CODES[i];
        return 8'h80 >> (i - 64);
    endfunction

    function automatic bit [7:0] ref_enc(bit [63:0] d);
        bit [7:0] c = '0;
        for (int i = 0; i < 64; i++) begin
            if (d[i]) c = c ^ CODES[i];
        end
        return c;
    endfunction

    function automatic exp_t ref_dec(bit [63:0] d, bit [7:0] c, string tag);
        exp_t e;
        e.valid  = 1'b1;
        e.data   = d;
        e.syn    = ref_enc(d) ^ c;
        e.corr   = 1'b0;
        e.uncorr = 1'b0;
        e.idx    = '0;
        e.tag    = tag;
        if (e.syn != 0) begin
            e.uncorr = 1'b1;
            for (int i = 0; i < 72; i++) begin
                if (ref_code(i) == e.syn) begin
                    e.uncorr = 1'b0;
                    e.corr   = 1'b1;
                    e.idx    = 7'(i);
                    if (i < 64) e.data[i] = ~e.data[i];
                end
            end
        end
        return e;
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_total++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic compare_out();
        exp_t e;
        if (pend.size() == 0) return;
        e = pend.pop_front();
        check("R8 out_valid", 64'(out_valid), 64'(e.valid));
        if (e.valid) begin
            check("R2 syndrome", 64'(out_syndrome), 64'(e.syn));
            check({e.tag, " data"}, out_data, e.data);
            check({e.tag, " corr"}, 64'(out_corr), 64'(e.corr));
            check({e.tag, " uncorr"}, 64'(out_uncorr), 64'(e.uncorr));
            check({e.tag, " idx"}, 64'(out_idx), 64'(e.idx));
            check("R9 flags exclusive", 64'(out_corr & out_uncorr), 64'd0);
        end else begin
            check("R8 idle outputs", 64'({out_data != 0, out_syndrome != 0,
                  out_corr, out_uncorr, out_idx != 0}), 64'd0);
        end
    endtask

    // One clock: compare the previous result, then drive a new read.
    task automatic step(bit v, bit [63:0] d, bit [7:0] c, string tag);
        exp_t e;
        @(negedge clk);
        compare_out();
        rd_valid = v;
        rd_data  = d;
        rd_chk   = c;
        wr_data  = d;
        #1;
        check("R1 wr_chk", 64'(wr_chk), 64'(ref_enc(d)));
        if (v) begin
            e = ref_dec(d, c, tag);
        end else begin
            e = '{valid: 1'b0, data: '0, syn: '0, corr: 1'b0,
                  uncorr: 1'b0, idx: '0, tag: tag};
        end
        pend.push_back(e);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_total, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        bit [63:0] pats [4];
        pats[0] = 64'h0101_0101_0101_0101;
        pats[1] = 64'h0000_0000_0000_0000;
        pats[2] = 64'hFFFF_FFFF_FFFF_FFFF;
        pats[3] = 64'hA5C3_1E7F_0F96_3C5A;

        rst_n    = 1'b0;
        rd_valid = 1'b0;
        rd_data  = '0;
        rd_chk   = '0;
        wr_data  = '0;
        repeat (3) @(negedge clk);
        // R8: reset state
        check("R8 reset", 64'({out_valid, out_corr, out_uncorr,
              out_syndrome != 0, out_data != 0, out_idx != 0}), 64'd0);
        rst_n = 1'b1;

        for (int p = 0; p < 4; p++) begin
            bit [7:0] good;
            good = ref_enc(pats[p]);
            step(1'b1, pats[p], good, "R3");
            step(1'b0, '0, '0, "R8");
            for (int i = 0; i < 64; i += ((p == 0) ? 1 : 7)) begin
                step(1'b1, pats[p] ^ (64'd1 << i), good, "R4");
            end
            for (int j = 0; j < 8; j++) begin
                step(1'b1, pats[p], good ^ (8'd1 << j), "R5");
            end
            for (int i = 0; i < 58; i += 9) begin
                step(1'b1, pats[p] ^ (64'd1 << i) ^ (64'd1 << (i + 6)),
                     good, "R6");
            end
            step(1'b1, pats[p], good ^ 8'h03, "R7");
            step(1'b1, pats[p], good ^ 8'hC0, "R7");
            step(1'b0, '0, '0, "R8");
        end
        step(1'b0, '0, '0, "R8");
        @(negedge clk);
        compare_out();
        finish_run();
    end
endmodule